// File: doc/BRIEF.md
# Looping Melody Square-Wave Player

This block plays a fixed tune of 64 steps on a single audio pin, over and over. A free-running tick counter advances only while the block is enabled. Its upper bits select the current step. A step-to-note lookup turns the step into a 3-bit note code. A second lookup turns the note code into a 16-bit half-period reload value.

A down-counting divider reloads from that value at each terminal count and inverts the output there. Each note therefore comes out as a square wave with equal high and low times. Note code 0 is a rest, and during a rest the pin stays low.

The block is meant to drive a small speaker through a series resistor. It needs a clock, a synchronous reset and an enable. Two parameters let a small configuration run fast for checking:

- `STEP_LSB` sets the step length.
- `DIV_SHIFT` scales the pitch values down.

Top module: `melody_player`

## Requirements
- R1: While `rst` is high at a clock edge, the tick counter and the divider clear and `audio` is 0 after that edge.
- R2: The step index is bits [STEP_LSB+5:STEP_LSB] of the count of enabled clock edges since reset. Each step lasts 2^STEP_LSB enabled clocks, and step 63 wraps to step 0.
- R3: Steps 0 to 31 carry the note codes 5,5,0,0,3,0,3,0,5,5,0,0,3,0,3,0,5,0,4,0,3,0,2,0,1,1,1,1,0,0,0,0.
- R4: Steps 32 to 63 carry the note codes 6,6,0,0,7,0,6,0,5,5,0,0,3,0,3,0,5,0,4,0,3,0,2,0,1,1,1,1,0,0,0,0.
- R5: Note codes 1 to 7 select the reload values 48112, 42864, 38192, 36048, 32112, 28608 and 24064, each shifted right by DIV_SHIFT. Code 0 selects 0.
- R6: When the divider is at zero on an enabled edge, it reloads the current note's value. On that same edge `audio` inverts when the note is not a rest. Between two such inversions inside one step, exactly reload+1 enabled clocks pass.
- R7: On an enabled edge at which the divider is at zero and the current note code is 0, `audio` becomes 0. `audio` never rises during a rest step.
- R8: On an edge with `en` low, `audio` becomes 0 and the tick counter and divider hold their values. Playback resumes from the held position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance and sound enable |
| audio | output | 1 | Registered square-wave output |

## Verification
The bench plays a full lap of the tune and on into the wrap, in a configuration with short steps and shifted pitch values. It times every pair of inversions that fall inside one step against the shifted table value plus one.

- A wrong entry in either lookup shows up as a wrong half-period in that step.
- An off-by-one reload shows up as every interval being one clock off.
- Wrong step bits shift the pitch boundaries, so notes are measured in the wrong steps.

During rests the bench watches for any rise of the output, which catches a design that keeps toggling with a zero reload. A long disable window tests the hold behaviour. Sound must stop, and a counter that kept running would land later intervals in the wrong notes. A mid-run reset must silence the output.

// File: rtl/melody_pkg.sv
package melody_pkg;
  localparam int STEP_BITS = 6;
  localparam int NOTE_W    = 3;
  localparam int DIV_W     = 16;
  typedef logic [NOTE_W-1:0]    note_t;
  typedef logic [STEP_BITS-1:0] step_t;
  typedef logic [DIV_W-1:0]     div_t;
  localparam note_t NOTE_REST = '0;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (en)  count <= count + 1'b1;
  end
endmodule

// File: rtl/melody_rom.sv
module melody_rom
  import melody_pkg::*;
(
  input  step_t step,
  output note_t note
);
  note_t tail;
  note_t head;

  // notes shared by both halves of the tune (steps 8..31 of each half)
  always_comb begin
    case (step[4:0])
      5'd8, 5'd9, 5'd16:                tail = 3'd5;
      5'd12, 5'd14, 5'd20:              tail = 3'd3;
      5'd18:                            tail = 3'd4;
      5'd22:                            tail = 3'd2;
      5'd24, 5'd25, 5'd26, 5'd27:       tail = 3'd1;
      default:                          tail = NOTE_REST;
    endcase
  end

  // opening bar differs between the halves
  always_comb begin
    case (step[2:0])
      3'd0, 3'd1: head = step[5] ? 3'd6 : 3'd5;
      3'd4:       head = step[5] ? 3'd7 : 3'd3;
      3'd6:       head = step[5] ? 3'd6 : 3'd3;
      default:    head = NOTE_REST;
    endcase
  end

  assign note = (step[4:3] == 2'b00) ? head : tail;
endmodule

// File: rtl/pitch_table.sv
module pitch_table
  import melody_pkg::*;
#(
  parameter int DIV_SHIFT = 0
) (
  input  note_t note,
  output div_t  reload
);
  div_t base;
  always_comb begin
    case (note)
      3'd1:    base = 16'd48112;
      3'd2:    base = 16'd42864;
      3'd3:    base = 16'd38192;
      3'd4:    base = 16'd36048;
      3'd5:    base = 16'd32112;
      3'd6:    base = 16'd28608;
      3'd7:    base = 16'd24064;
      default: base = '0;
    endcase
  end
  assign reload = base >> DIV_SHIFT;
endmodule

// File: rtl/tone_divider.sv
module tone_divider
  import melody_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  div_t reload,
  input  logic rest,
  output div_t remain,
  output logic audio
);
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      audio  <= 1'b0;
    end else if (!en) begin
      audio  <= 1'b0;
    end else if (remain == '0) begin
      remain <= reload;
      audio  <= rest ? 1'b0 : ~audio;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/melody_player.sv
module melody_player
  import melody_pkg::*;
#(
  parameter int STEP_LSB  = 21,
  parameter int DIV_SHIFT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic audio
);
  localparam int CNT_W = STEP_LSB + STEP_BITS;

  logic [CNT_W-1:0] ticks;
  step_t            step;
  note_t            note;
  div_t             reload;
  div_t             remain;

  tick_counter #(.CNT_W(CNT_W)) u_ticks (
    .clk(clk), .rst(rst), .en(en), .count(ticks)
  );

  assign step = ticks[CNT_W-1:STEP_LSB];

  melody_rom u_rom (.step(step), .note(note));

  pitch_table #(.DIV_SHIFT(DIV_SHIFT)) u_pitch (.note(note), .reload(reload));

  tone_divider u_div (
    .clk(clk), .rst(rst), .en(en), .reload(reload),
    .rest(note == NOTE_REST), .remain(remain), .audio(audio)
  );
endmodule

// File: rtl/melody_player_chk.sv
module melody_player_chk
  import melody_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             audio,
  input logic [CNT_W-1:0] ticks,
  input note_t            note,
  input div_t             reload,
  input div_t             remain
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!audio && ticks == '0 && remain == '0)); // R1
  AST_TICK_ADV: assert property (@(posedge clk) disable iff (rst) en |=> ticks == $past(ticks) + 1'b1); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst) (en && remain == '0) |=> remain == $past(reload)); // R6
  AST_TOGGLE: assert property (@(posedge clk) disable iff (rst) (en && remain == '0 && note != NOTE_REST) |=> audio != $past(audio)); // R6
  AST_REST_LOW: assert property (@(posedge clk) disable iff (rst) (en && remain == '0 && note == NOTE_REST) |=> !audio); // R7
  AST_DIS_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> (!audio && $stable(ticks) && $stable(remain))); // R8
endmodule

bind melody_player melody_player_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .audio(audio), .ticks(ticks),
  .note(note), .reload(reload), .remain(remain)
);

// File: tb/melody_player_tb.sv
`timescale 1ns/1ps
module melody_player_tb;
  localparam int LSB   = 10;
  localparam int SHIFT = 8;
  localparam int STEPLEN = 1 << LSB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic audio;

  melody_player #(.STEP_LSB(LSB), .DIV_SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst(rst), .en(en), .audio(audio)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // R3 / R4: tune written out independently
  int tune [64] = '{5,5,0,0,3,0,3,0,5,5,0,0,3,0,3,0,5,0,4,0,3,0,2,0,1,1,1,1,0,0,0,0,
                    6,6,0,0,7,0,6,0,5,5,0,0,3,0,3,0,5,0,4,0,3,0,2,0,1,1,1,1,0,0,0,0};
  // R5: pitch values
  int pitch [8] = '{0,48112,42864,38192,36048,32112,28608,24064};

  // bench-side view of edges
  int   n = 0;
  logic en_e = 1'b0, rst_e = 1'b1;
  always @(posedge clk) begin
    en_e  <= en;
    rst_e <= rst;
    if (rst) n <= 0;
    else if (en) n <= n + 1;
  end

  logic        last_audio = 1'b0;
  logic        have_prev = 1'b0;
  int          prev_n = 0;
  int          prev_step = -1;
  logic [63:0] seen = '0;
  logic        rest_bad = 1'b0;
  logic        dis_checked = 1'b0;

  function automatic int exp_half(int s);
    return (pitch[tune[s]] >> SHIFT) + 1;
  endfunction

  always @(negedge clk) begin
    if (rst_e) begin
      have_prev = 1'b0;
      rest_bad  = 1'b0;
    end else if (!en_e) begin
      have_prev = 1'b0;
      if (!dis_checked) begin
        checks++;
        if (audio !== 1'b0) begin
          fails++;
          $display("FAIL R8: audio while disabled act=%b exp=0", audio);
        end
        dis_checked = 1'b1;
      end else if (audio !== 1'b0) begin
        fails++;
        $display("FAIL R8: audio while disabled act=%b exp=0", audio);
      end
    end else if (n >= 1) begin
      int s;
      int off;
      dis_checked = 1'b0;
      s   = ((n - 1) >> LSB) & 63;
      off = (n - 1) & (STEPLEN - 1);
      if (audio !== last_audio) begin
        if (tune[s] == 0 && audio === 1'b1) begin
          checks++; fails++;
          $display("FAIL R7: rise in rest step %0d act=1 exp=0", s);
        end
        if (have_prev && prev_step == s && tune[s] != 0) begin
          checks++;
          seen[s] = 1'b1;
          if (n - prev_n != exp_half(s)) begin
            fails++;
            $display("FAIL R6 (R2/R3/R4/R5): step %0d half-period act=%0d exp=%0d",
                     s, n - prev_n, exp_half(s));
          end
        end
        have_prev = 1'b1;
        prev_n    = n;
        prev_step = s;
      end
      if (tune[s] == 0 && off >= STEPLEN/2 && audio !== 1'b0) rest_bad = 1'b1;
      if (off == STEPLEN - 1 && tune[s] == 0) begin
        checks++;
        if (rest_bad) begin
          fails++;
          $display("FAIL R7: rest step %0d sounded act=1 exp=0", s);
        end
        rest_bad = 1'b0;
      end
    end
    last_audio = audio;
  end

  task automatic wait_n(int target);
    while (n < target) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (audio !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset audio act=%b exp=0", audio);
    end
    rst = 1'b0;
    en  = 1'b1;
    wait_n(3*STEPLEN + 300);
    en = 1'b0;                       // R8: long hold window
    repeat (3000) @(negedge clk);
    en = 1'b1;
    wait_n(64*STEPLEN + 2*STEPLEN);  // R2: wrap into step 0/1
    for (int s = 0; s < 64; s++) begin
      if (tune[s] != 0) begin
        checks++;
        if (!seen[s]) begin
          fails++;
          $display("FAIL %s: step %0d never measured act=0 exp=1", (s < 32) ? "R3" : "R4", s);
        end
      end
    end
    rst = 1'b1;                      // R1: mid-run reset
    @(negedge clk);
    checks++;
    if (audio !== 1'b0) begin
      fails++;
      $display("FAIL R1: audio after reset act=%b exp=0", audio);
    end
    rst = 1'b0;
    wait_n(STEPLEN);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule